// File: doc/BRIEF.md
# Multi-Mode Receive Word Aligner

This block takes a deserialized receive stream, presented as 10 or 20 bits per clock with the first bit on the wire in bit 0, and recovers the symbol boundary. Each cycle it joins the previous word (low half) and the current word (high half) into a double-width window. The realigned output word is cut from that window at the current boundary offset. An alignment pattern of selectable length is searched for at every bit offset of the window, so a pattern that straddles two incoming words is still found.

Three alignment policies are selectable at run time. In slip mode, each rising edge of a slip request advances the boundary by one bit, which discards the oldest bit. In manual mode, a rising edge of an align request arms a one-shot realignment to the next pattern found. In sync mode, a counting state machine moves the boundary to the pattern and asserts sync status after a set number of patterns. It tolerates isolated misaligned patterns before it drops lock. A fourth mode code freezes the boundary.

Top module: `rx_word_aligner`

## Requirements
- R1: On synchronous reset, `offsetOut`, `syncStatus`, `patDet` and `alignedData` are all zero.
- R2: Each clock, `alignedData` is loaded with bits `offsetOut` to `offsetOut+W-1` of the window {current `dataIn`, previous `dataIn`}, where the previous word forms bits 0..W-1. A new offset takes effect on the output word registered at the edge after the one that changed it.
- R3: With `modeIn` = 0 (slip), a rising edge of `slipReq` increases `offsetOut` by exactly one, and W-1 wraps to 0. Holding `slipReq` high causes no further change.
- R4: The pattern is compared bit 0 first. Only the low `patLen` bits of `pattern` take part. `patDet` rises with the output word whose low bits carry the pattern at the current offset.
- R5: With `modeIn` = 2 (manual), a rising edge of `alignReq` arms realignment. The first window with a match (the same cycle included) loads `offsetOut` with the lowest matching offset and disarms. A held `alignReq` level triggers no later realignment.
- R6: With `modeIn` = 1 (sync), a pattern at another offset moves the boundary there and counts one. Each pattern at the current offset counts one more. `syncStatus` rises when the count reaches SYNC_PATTERNS (1 to 256, default 3).
- R7: While locked, a word whose only matches lie off the current boundary is an error. Lock drops on the fourth error. Each run of four non-error words while locked retires one error, so a single error never drops lock.
- R8: In any mode other than sync, `syncStatus` is low from the next cycle on, and the count state is cleared.
- R9: With `modeIn` = 3 (hold), neither slip nor align requests change `offsetOut`.
- R10: A match is accepted only at offsets k where k + `patLen` <= 2W. Supported lengths are 7, 8, 10, 16, 20, 32 and 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | W | Raw parallel receive word, first bit in bit 0 |
| modeIn | input | 2 | 0 slip, 1 sync, 2 manual, 3 hold |
| slipReq | input | 1 | Slip request, acts on rising edge |
| alignReq | input | 1 | Manual align request, acts on rising edge |
| pattern | input | PAT_W | Alignment pattern, first bit in bit 0 |
| patLen | input | LEN_W | Number of pattern bits compared |
| alignedData | output | W | Realigned output word |
| offsetOut | output | $clog2(W) | Current boundary offset |
| patDet | output | 1 | Pattern present at the boundary of `alignedData` |
| syncStatus | output | 1 | Lock indication in sync mode |

## Verification
The hardest state to reach is a lock held with errors already counted, sitting right at the edge of dropping. Getting there needs misaligned patterns spaced so that the runs of good words between them stay shorter than four, followed by exactly one run long enough to retire an error. The bench builds zero-background bursts with one pattern at a chosen bit shift. Each burst gives exactly one matching window between two clean ones, so the error and good-run counts can be worked out arithmetically per word. Boundary offsets are swept over every value in slip and manual modes. The window-fit limit is probed with a 16-bit pattern placed both where it fits and where it does not.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;

  typedef enum logic [1:0] {
    MODE_SLIP   = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_MANUAL = 2'd2,
    MODE_HOLD   = 2'd3
  } alignMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic slipOne;    // advance boundary by one bit
    logic loadMatch;  // move boundary to lowest matching offset
  } alignStrobe_t;

endpackage

// File: rtl/rxwa_datapath.sv
module rxwa_datapath
  import rxwa_pkg::*;
#(
  parameter int W     = 10,
  parameter int PAT_W = 40,
  parameter int LEN_W = 6,
  localparam int OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     dataIn,
  input  logic [PAT_W-1:0] pattern,
  input  logic [LEN_W-1:0] patLen,
  input  alignStrobe_t     strobe,
  output logic [W-1:0]     alignedData,
  output logic [OFF_W-1:0] offsetOut,
  output logic             patDet,
  output logic             matchAny,
  output logic             matchAtOffset
);

  localparam int WIN_W = 2 * W;
  localparam int EXT_W = WIN_W + PAT_W;

  logic [W-1:0]     prevData;
  logic [WIN_W-1:0] window;
  logic [EXT_W-1:0] winExt;
  logic [WIN_W-1:0] winShift;
  logic [PAT_W-1:0] lenMask;
  logic [W-1:0]     hit;
  logic [OFF_W-1:0] matchPos;
  logic [OFF_W-1:0] offsetQ;

  assign window   = {dataIn, prevData};
  assign winExt   = {{PAT_W{1'b0}}, window};
  assign winShift = window >> offsetQ;

  always_comb begin
    for (int i = 0; i < PAT_W; i++) begin
      lenMask[i] = (i < int'(patLen));
    end
  end

  // one comparator per candidate offset
  generate
    for (genvar k = 0; k < W; k++) begin : g_cmp
      logic fits;
      assign fits   = (k + int'(patLen)) <= WIN_W;
      assign hit[k] = fits && (((winExt[k +: PAT_W] ^ pattern) & lenMask) == '0);
    end
  endgenerate

  // lowest offset wins
  always_comb begin
    matchPos = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit[k]) matchPos = OFF_W'(k);
    end
  end

  assign matchAny      = |hit;
  assign matchAtOffset = hit[offsetQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      prevData    <= '0;
      offsetQ     <= '0;
      alignedData <= '0;
      patDet      <= 1'b0;
    end else begin
      prevData    <= dataIn;
      alignedData <= winShift[W-1:0];
      patDet      <= matchAtOffset;
      if (strobe.loadMatch) begin
        offsetQ <= matchPos;
      end else if (strobe.slipOne) begin
        offsetQ <= (offsetQ == OFF_W'(W - 1)) ? '0 : offsetQ + 1'b1;
      end
    end
  end

  assign offsetOut = offsetQ;

endmodule

// File: rtl/rxwa_control.sv
module rxwa_control
  import rxwa_pkg::*;
#(
  parameter int SYNC_PATTERNS = 3,
  localparam int CNT_W = $clog2(SYNC_PATTERNS + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   modeIn,
  input  logic         slipReq,
  input  logic         alignReq,
  input  logic         matchAny,
  input  logic         matchAtOffset,
  output alignStrobe_t strobe,
  output logic         syncStatus
);

  alignMode_e       mode;
  logic             slipPrev, alignPrev, armed;
  logic             locked;
  logic [CNT_W-1:0] goodCnt, nextCnt;
  logic [2:0]       errCnt;
  logic [1:0]       goodRun;
  logic             alignEdge, badWord;

  assign mode      = alignMode_e'(modeIn);
  assign alignEdge = alignReq & ~alignPrev;
  assign badWord   = matchAny & ~matchAtOffset;
  assign nextCnt   = matchAtOffset ? goodCnt + 1'b1 : CNT_W'(1);

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_SLIP:   strobe.slipOne   = slipReq & ~slipPrev;
      MODE_MANUAL: strobe.loadMatch = (armed | alignEdge) & matchAny;
      MODE_SYNC:   strobe.loadMatch = ~locked & badWord;
      MODE_HOLD:   strobe = '0;
      default:     strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slipPrev  <= 1'b0;
      alignPrev <= 1'b0;
      armed     <= 1'b0;
      locked    <= 1'b0;
      goodCnt   <= '0;
      errCnt    <= '0;
      goodRun   <= '0;
    end else begin
      slipPrev  <= slipReq;
      alignPrev <= alignReq;

      if (mode != MODE_MANUAL) armed <= 1'b0;
      else if (armed | alignEdge) armed <= ~matchAny;

      if (mode != MODE_SYNC) begin
        locked  <= 1'b0;
        goodCnt <= '0;
        errCnt  <= '0;
        goodRun <= '0;
      end else if (!locked) begin
        if (matchAny) begin
          if (nextCnt >= CNT_W'(SYNC_PATTERNS)) begin
            locked  <= 1'b1;
            goodCnt <= '0;
            errCnt  <= '0;
            goodRun <= '0;
          end else begin
            goodCnt <= nextCnt;
          end
        end
      end else if (badWord) begin
        goodRun <= '0;
        if (errCnt == 3'd3) begin
          locked  <= 1'b0;
          errCnt  <= '0;
          goodCnt <= '0;
        end else begin
          errCnt <= errCnt + 1'b1;
        end
      end else if (goodRun == 2'd3) begin
        goodRun <= '0;
        if (errCnt != 3'd0) errCnt <= errCnt - 1'b1;
      end else begin
        goodRun <= goodRun + 1'b1;
      end
    end
  end

  assign syncStatus = locked;

endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
  import rxwa_pkg::*;
#(
  parameter int W             = 10,
  parameter int PAT_W         = 40,
  parameter int LEN_W         = 6,
  parameter int SYNC_PATTERNS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         dataIn,
  input  logic [1:0]           modeIn,
  input  logic                 slipReq,
  input  logic                 alignReq,
  input  logic [PAT_W-1:0]     pattern,
  input  logic [LEN_W-1:0]     patLen,
  output logic [W-1:0]         alignedData,
  output logic [$clog2(W)-1:0] offsetOut,
  output logic                 patDet,
  output logic                 syncStatus
);

  alignStrobe_t strobe;
  logic         matchAny, matchAtOffset;

  rxwa_control #(.SYNC_PATTERNS(SYNC_PATTERNS)) u_ctrl (
    .clk(clk), .rst(rst), .modeIn(modeIn), .slipReq(slipReq),
    .alignReq(alignReq), .matchAny(matchAny), .matchAtOffset(matchAtOffset),
    .strobe(strobe), .syncStatus(syncStatus)
  );

  rxwa_datapath #(.W(W), .PAT_W(PAT_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .dataIn(dataIn), .pattern(pattern),
    .patLen(patLen), .strobe(strobe), .alignedData(alignedData),
    .offsetOut(offsetOut), .patDet(patDet), .matchAny(matchAny),
    .matchAtOffset(matchAtOffset)
  );

endmodule

// File: rtl/rxwa_checker.sv
module rxwa_checker #(
  parameter int W     = 10,
  parameter int PAT_W = 40,
  parameter int LEN_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           modeIn,
  input logic                 slipReq,
  input logic [PAT_W-1:0]     pattern,
  input logic [LEN_W-1:0]     patLen,
  input logic [W-1:0]         alignedData,
  input logic [$clog2(W)-1:0] offsetOut,
  input logic                 patDet,
  input logic                 syncStatus
);

  logic [W-1:0] wordMask;
  always_comb begin
    for (int i = 0; i < W; i++) wordMask[i] = (i < int'(patLen));
  end

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(offsetOut) < W); // R3

  AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
    (modeIn == 2'd0 && slipReq && !$past(slipReq)) |=>
    (offsetOut == (($past(offsetOut) == ($clog2(W))'(W - 1)) ? '0 : $past(offsetOut) + 1'b1))); // R3

  AST_SLIP_HELD: assert property (@(posedge clk) disable iff (rst)
    (modeIn == 2'd0 && slipReq && $past(slipReq)) |=> $stable(offsetOut)); // R3

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (modeIn == 2'd3) |=> $stable(offsetOut)); // R9

  AST_SYNC_ONLY_IN_SM: assert property (@(posedge clk) disable iff (rst)
    (modeIn != 2'd1) |=> !syncStatus); // R8

  AST_PATDET_WORD: assert property (@(posedge clk) disable iff (rst)
    patDet |-> (((alignedData ^ $past(pattern[W-1:0])) & $past(wordMask)) == '0)); // R4

endmodule

bind rx_word_aligner rxwa_checker #(.W(W), .PAT_W(PAT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .modeIn(modeIn), .slipReq(slipReq), .pattern(pattern),
  .patLen(patLen), .alignedData(alignedData), .offsetOut(offsetOut),
  .patDet(patDet), .syncStatus(syncStatus)
);

// File: tb/sim_rx_word_aligner.sv
module sim_rx_word_aligner;

  localparam int W = 10;
  localparam logic [9:0] PAT10 = 10'b0101111100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  dataIn = '0;
  logic [1:0]  modeIn = 2'd0;
  logic        slipReq = 1'b0, alignReq = 1'b0;
  logic [39:0] pattern = '0;
  logic [5:0]  patLen = 6'd10;
  logic [9:0]  alignedData;
  logic [3:0]  offsetOut;
  logic        patDet, syncStatus;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [9:0] curW = '0, prevW = '0, lastPatWord = '0;
  bit sawPat = 0;

  always #4 clk = ~clk;

  rx_word_aligner u0 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .modeIn(modeIn), .slipReq(slipReq),
    .alignReq(alignReq), .pattern(pattern), .patLen(patLen),
    .alignedData(alignedData), .offsetOut(offsetOut), .patDet(patDet),
    .syncStatus(syncStatus)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic sendWord(input logic [9:0] w, input logic sl, input logic al);
    dataIn = w; slipReq = sl; alignReq = al;
    prevW = curW; curW = w;
    @(posedge clk); @(negedge clk);
    if (patDet) begin sawPat = 1; lastPatWord = alignedData; end
  endtask

  task automatic burst(input logic [29:0] v, input logic al);
    sendWord(v[9:0], 1'b0, al);
    sendWord(v[19:10], 1'b0, al);
    sendWord(v[29:20], 1'b0, al);
  endtask

  function automatic logic [29:0] place(input logic [39:0] p, input int len, input int s);
    logic [39:0] m;
    m = p & ((40'd1 << len) - 1);
    return 30'(m << s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int off;
    logic [19:0] tmp;
    pattern = {30'd0, PAT10};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(offsetOut == 0, "R1 offset", offsetOut, 0);
    check(syncStatus == 0, "R1 sync", syncStatus, 0);
    check(patDet == 0, "R1 patDet", patDet, 0);
    check(alignedData == 0, "R1 data", alignedData, 0);
    rst = 0;

    // R2/R3 slip sweep over every offset, then wrap
    modeIn = 2'd0;
    off = 0;
    for (int i = 0; i <= 10; i++) begin
      sendWord(10'((i * 97 + 13) % 1024), 1'b0, 1'b0);
      sendWord(10'((i * 211 + 7) % 1024), 1'b0, 1'b0);
      tmp = {curW, prevW} >> off;
      check(alignedData == tmp[9:0], "R2 aligned word", alignedData, tmp[9:0]);
      check(offsetOut == 4'(off), "R3 slip offset", offsetOut, off);
      if (i < 10) begin
        sendWord(10'h155, 1'b1, 1'b0);
        off = (off + 1) % W;
      end
    end
    // R3 held slip: only one step
    for (int i = 0; i < 4; i++) sendWord(10'h0, 1'b1, 1'b0);
    sendWord(10'h0, 1'b0, 1'b0);
    check(offsetOut == 4'd1, "R3 held slip", offsetOut, 1);

    // R9 hold mode ignores requests
    modeIn = 2'd3;
    sendWord(10'h0, 1'b1, 1'b1);
    burst(place({30'd0, PAT10}, 10, 6), 1'b0);
    sendWord(10'h0, 1'b0, 1'b0);
    check(offsetOut == 4'd1, "R9 hold", offsetOut, 1);

    // R5/R4 manual sweep
    modeIn = 2'd2;
    for (int s = 0; s < 10; s++) begin
      sendWord(10'h0, 1'b0, 1'b1);
      sendWord(10'h0, 1'b0, 1'b0);
      burst(place({30'd0, PAT10}, 10, s), 1'b0);
      sendWord(10'h0, 1'b0, 1'b0);
      check(offsetOut == 4'(s), "R5 manual offset", offsetOut, s);
      sawPat = 0;
      burst(place({30'd0, PAT10}, 10, s), 1'b0);
      sendWord(10'h0, 1'b0, 1'b0);
      check(sawPat && lastPatWord == PAT10, "R4 patDet word", lastPatWord, PAT10);
    end
    // R5 held level realigns once only
    sendWord(10'h0, 1'b0, 1'b1);
    burst(place({30'd0, PAT10}, 10, 7), 1'b1);
    check(offsetOut == 4'd7, "R5 edge align", offsetOut, 7);
    burst(place({30'd0, PAT10}, 10, 2), 1'b1);
    sendWord(10'h0, 1'b0, 1'b1);
    check(offsetOut == 4'd7, "R5 held level", offsetOut, 7);
    sendWord(10'h0, 1'b0, 1'b0);

    // R4 short length: upper pattern bits ignored
    pattern = 40'hAB_CDEF_FF80 | {33'd0, PAT10[6:0]};
    patLen = 6'd7;
    sendWord(10'h0, 1'b0, 1'b1);
    burst(place(pattern, 7, 4), 1'b0);
    sendWord(10'h0, 1'b0, 1'b0);
    check(offsetOut == 4'd4, "R4 len7 align", offsetOut, 4);

    // R10 window fit
    pattern = {30'd0, PAT10};
    patLen = 6'd16;
    sendWord(10'h0, 1'b0, 1'b1);
    sendWord(10'h0, 1'b0, 1'b0);
    burst(place(pattern, 16, 6), 1'b0);
    sendWord(10'h0, 1'b0, 1'b0);
    check(offsetOut == 4'd4, "R10 no fit", offsetOut, 4);
    sendWord(10'h0, 1'b0, 1'b1);
    sendWord(10'h0, 1'b0, 1'b0);
    burst(place(pattern, 16, 2), 1'b0);
    sendWord(10'h0, 1'b0, 1'b0);
    check(offsetOut == 4'd2, "R10 fit", offsetOut, 2);

    // R6 acquisition with default count of 3
    patLen = 6'd10;
    modeIn = 2'd1;
    sendWord(10'h0, 1'b0, 1'b0);
    burst(place(pattern, 10, 3), 1'b0);
    check(offsetOut == 4'd3, "R6 move boundary", offsetOut, 3);
    check(syncStatus == 0, "R6 one pattern", syncStatus, 0);
    burst(place(pattern, 10, 3), 1'b0);
    check(syncStatus == 0, "R6 two patterns", syncStatus, 0);
    burst(place(pattern, 10, 3), 1'b0);
    check(syncStatus == 1, "R6 three patterns", syncStatus, 1);

    // R7 hysteresis
    for (int b = 0; b < 3; b++) burst(place(pattern, 10, 5), 1'b0);
    check(syncStatus == 1, "R7 three errors", syncStatus, 1);
    for (int z = 0; z < 4; z++) sendWord(10'h0, 1'b0, 1'b0);
    burst(place(pattern, 10, 5), 1'b0);
    check(syncStatus == 1, "R7 retired error", syncStatus, 1);
    check(offsetOut == 4'd3, "R7 boundary kept", offsetOut, 3);
    burst(place(pattern, 10, 5), 1'b0);
    check(syncStatus == 0, "R7 lock lost", syncStatus, 0);

    // R8 relock then leave sync mode
    for (int b = 0; b < 3; b++) burst(place(pattern, 10, 5), 1'b0);
    check(syncStatus == 1, "R6 relock", syncStatus, 1);
    check(offsetOut == 4'd5, "R6 relock offset", offsetOut, 5);
    modeIn = 2'd0;
    sendWord(10'h0, 1'b0, 1'b0);
    check(syncStatus == 0, "R8 mode exit", syncStatus, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule